// File: doc/BRIEF.md
# S-Record Stream Decoder

This block turns a stream of ASCII characters into byte writes for memory. Characters arrive one per `in_valid`/`in_ready` handshake. The block parses Motorola S-records and issues one write strobe, with its address and data, for each payload byte of a data record. It checks the checksum of every record and raises a one-cycle `done` pulse when a terminating record checks out. While it runs, it keeps the lowest and highest addresses it has written. A loader sits in front of it to supply the characters. A memory or memory controller sits behind it to take the writes.

A write goes out as soon as its second hex character arrives. The checksum verdict only comes at the end of the record, so a record that ends with `cksum_err` has already written bytes that must be treated as suspect. A character that does not fit the record grammar aborts the record and pulses `fmt_err`. After an abort the decoder waits for the next start character.

Top module: `srec_stream_decoder`

## Requirements
- R1: Reset state. During reset and on the first cycle after it, `wr_en`, `done`, `cksum_err` and `fmt_err` are low, `addr_lo` is all ones, `addr_hi` is zero and `addr_seen` is low. From the second cycle after reset onward, `in_ready` stays high.
- R2: Between records, carriage return (0x0D) and line feed (0x0A) are ignored. Any other character except 'S' (0x53) causes a `fmt_err` pulse on the cycle after the character is accepted.
- R3: A record starts with 'S' and is followed by one type digit. The accepted types are '0', '1', '2', '3', '7', '8' and '9'. Any other character in the type position pulses `fmt_err` and abandons the record.
- R4: Every field byte is written as two hex characters, high nibble first. The digits 0-9, A-F and a-f are accepted. Any other character inside a record pulses `fmt_err`, and the decoder goes back to waiting for 'S'.
- R5: The address follows the count byte, most significant byte first. Its length is 2 bytes for types 0, 1 and 9, 3 bytes for types 2 and 8, and 4 bytes for types 3 and 7.
- R6: The count byte covers the address, data and checksum bytes, so the number of data bytes is count − address length − 1. If the count is less than address length + 1, `fmt_err` pulses on the cycle after the count's second character.
- R7: Each data byte of a type 1, 2 or 3 record produces a one-cycle `wr_en` on the cycle after its second character. `wr_addr` is the record address plus the byte's index, and `wr_data` is the byte.
- R8: The data bytes of type 0 records and of type 7, 8 and 9 records never produce a write.
- R9: A record is valid when the 8-bit sum of the count, address, data and checksum bytes equals 0xFF. If it does not, `cksum_err` pulses on the cycle after the checksum's second character. Writes already issued by that record are not withdrawn.
- R10: When a type 7, 8 or 9 record passes its checksum, `done` pulses on the cycle after its last character. A failing end record pulses `cksum_err` instead, and `done` stays low.
- R11: `addr_lo` and `addr_hi` hold the minimum and maximum of every `wr_addr` written since reset, including writes from records that fail their checksum. `addr_seen` goes high with the first write. All three change only on writes.
- R12: At most one of `done`, `cksum_err` and `fmt_err` is high in any cycle. `done` and `cksum_err` never stay high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A character is offered |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Decoder accepts a character this cycle |
| wr_en | output | 1 | Write strobe, one cycle per data byte |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write data |
| done | output | 1 | Valid terminating record received |
| cksum_err | output | 1 | Record failed its checksum |
| fmt_err | output | 1 | Malformed character, type or count |
| addr_lo | output | ADDR_W | Lowest address written since reset |
| addr_hi | output | ADDR_W | Highest address written since reset |
| addr_seen | output | 1 | At least one write since reset |

## Verification
The bench builds the decoder with the default `ADDR_W` of 32. This means four-byte addresses from type 3 records reach `wr_addr` without being cut off. One such record has its payload cross from 0x8000FFFF to 0x80010000, which exposes a carry from the low 16 bits that a narrower build would hide. With the full width, `addr_hi` also lands far above the 16-bit records, so an off-by-one in the range tracker shows up in the final check.

// File: rtl/srec_pkg.sv
// Package for the S-record decoder.
// Holds the parser states, the record kinds and the character codes
// the decoder matches against.
package srec_pkg;

    // Widest address any record type can carry.
    localparam int REC_ADDR_BITS = 32;

    // Value the byte sum of a valid record must reach.
    localparam logic [7:0] CSUM_GOAL = 8'hFF;

    localparam logic [7:0] CH_START = 8'h53;  // 'S'
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TYPE,
        ST_COUNT,
        ST_ADDR,
        ST_DATA,
        ST_CSUM
    } srec_state_t;

    // What a record does with its payload.
    typedef enum logic [1:0] {
        RK_HEADER,
        RK_DATA,
        RK_END
    } rec_kind_t;

endpackage

// File: rtl/srec_hex_nibble.sv
// srec_hex_nibble: classifies one ASCII character as a hex digit and
// returns its value. Upper and lower case letters are both accepted.
// Assumes: purely combinational, no state.
module srec_hex_nibble (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib
);

    // Map '0'-'9', 'A'-'F' and 'a'-'f' to 0..15 and flag everything else.
    always_comb begin
        is_hex = 1'b1;
        nib    = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            nib = ch[3:0];
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            nib = ch[3:0] + 4'd9;
        end else begin
            is_hex = 1'b0;
        end
    end

endmodule

// File: rtl/srec_byte_pair.sv
// srec_byte_pair: joins two hex nibbles, high first, into one byte.
// byte_done is high in the cycle the second nibble is taken, and
// byte_val is valid in that same cycle.
// Assumes: flush is held high whenever the parser is outside a hex field,
// so every field starts on a high nibble.
module srec_byte_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       take,
    input  logic [3:0] nib,
    output logic       byte_done,
    output logic [7:0] byte_val
);

    logic       have_hi_q;
    logic [3:0] hi_q;

    // Remember the high nibble and track which half comes next.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            have_hi_q <= 1'b0;
            hi_q      <= 4'h0;
        end else if (take) begin
            have_hi_q <= ~have_hi_q;
            if (!have_hi_q) begin
                hi_q <= nib;
            end
        end
    end

    // A byte is finished when a nibble arrives while the high half is held.
    always_comb begin
        byte_done = take && have_hi_q;
        byte_val  = {hi_q, nib};
    end

endmodule

// File: rtl/srec_record_fsm.sv
// srec_record_fsm: walks through the fields of one S-record. It handles
// the start character, the type digit, the count, the address, the data
// and the checksum. It issues registered write strobes and the record
// result pulses.
// Assumes: acc marks an accepted character. byte_done/byte_val come from
// the nibble pairer, which is flushed while in_hex_field is low.
module srec_record_fsm
    import srec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [7:0]        ch,
    input  logic              is_hex,
    input  logic              byte_done,
    input  logic [7:0]        byte_val,
    output logic              in_hex_field,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              cksum_err,
    output logic              fmt_err
);

    localparam int FULL_W = REC_ADDR_BITS;

    srec_state_t       state_q;
    rec_kind_t         kind_q;
    logic [2:0]        alen_q;   // address bytes for this type
    logic [2:0]        acnt_q;   // address bytes still to come
    logic [7:0]        left_q;   // bytes still to come, checksum included
    logic [7:0]        sum_q;    // running sum of count, address, data
    logic [FULL_W-1:0] addr_q;   // address of the next data byte
    logic [7:0]        min_cnt;

    // Smallest count that leaves room for the address and the checksum.
    always_comb begin
        min_cnt      = {5'd0, alen_q} + 8'd1;
        in_hex_field = (state_q != ST_IDLE) && (state_q != ST_TYPE);
    end

    // Field sequencing, checksum accumulation and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            kind_q    <= RK_HEADER;
            alen_q    <= 3'd2;
            acnt_q    <= 3'd0;
            left_q    <= 8'd0;
            sum_q     <= 8'd0;
            addr_q    <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= 8'd0;
            done      <= 1'b0;
            cksum_err <= 1'b0;
            fmt_err   <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            done      <= 1'b0;
            cksum_err <= 1'b0;
            fmt_err   <= 1'b0;
            if (acc) begin
                case (state_q)
                    ST_IDLE: begin
                        if (ch == CH_START) begin
                            state_q <= ST_TYPE;
                        end else if (ch != CH_CR && ch != CH_LF) begin
                            fmt_err <= 1'b1;
                        end
                    end
                    ST_TYPE: begin
                        state_q <= ST_COUNT;
                        sum_q   <= 8'd0;
                        addr_q  <= '0;
                        case (ch)
                            8'h30: begin kind_q <= RK_HEADER; alen_q <= 3'd2; end
                            8'h31: begin kind_q <= RK_DATA;   alen_q <= 3'd2; end
                            8'h32: begin kind_q <= RK_DATA;   alen_q <= 3'd3; end
                            8'h33: begin kind_q <= RK_DATA;   alen_q <= 3'd4; end
                            8'h37: begin kind_q <= RK_END;    alen_q <= 3'd4; end
                            8'h38: begin kind_q <= RK_END;    alen_q <= 3'd3; end
                            8'h39: begin kind_q <= RK_END;    alen_q <= 3'd2; end
                            default: begin
                                fmt_err <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        endcase
                    end
                    default: begin
                        if (!is_hex) begin
                            fmt_err <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (byte_done) begin
                            case (state_q)
                                ST_COUNT: begin
                                    sum_q  <= byte_val;
                                    left_q <= byte_val;
                                    acnt_q <= alen_q;
                                    if (byte_val < min_cnt) begin
                                        fmt_err <= 1'b1;
                                        state_q <= ST_IDLE;
                                    end else begin
                                        state_q <= ST_ADDR;
                                    end
                                end
                                ST_ADDR: begin
                                    addr_q <= {addr_q[FULL_W-9:0], byte_val};
                                    sum_q  <= sum_q + byte_val;
                                    left_q <= left_q - 8'd1;
                                    acnt_q <= acnt_q - 3'd1;
                                    if (acnt_q == 3'd1) begin
                                        state_q <= (left_q == 8'd2) ? ST_CSUM : ST_DATA;
                                    end
                                end
                                ST_DATA: begin
                                    sum_q  <= sum_q + byte_val;
                                    left_q <= left_q - 8'd1;
                                    addr_q <= addr_q + 1'b1;
                                    if (kind_q == RK_DATA) begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= addr_q[ADDR_W-1:0];
                                        wr_data <= byte_val;
                                    end
                                    if (left_q == 8'd2) begin
                                        state_q <= ST_CSUM;
                                    end
                                end
                                default: begin
                                    state_q <= ST_IDLE;
                                    if (8'(sum_q + byte_val) == CSUM_GOAL) begin
                                        done <= (kind_q == RK_END);
                                    end else begin
                                        cksum_err <= 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/srec_range_track.sv
// srec_range_track: keeps the lowest and highest address written since
// reset, and a flag that is set once any write has happened.
// Assumes: wr_en is a single-cycle strobe with wr_addr valid alongside.
module srec_range_track #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic              addr_seen
);

    // Widen the bounds to include every address that is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo   <= '1;
            addr_hi   <= '0;
            addr_seen <= 1'b0;
        end else if (wr_en) begin
            addr_seen <= 1'b1;
            if (wr_addr < addr_lo) addr_lo <= wr_addr;
            if (wr_addr > addr_hi) addr_hi <= wr_addr;
        end
    end

endmodule

// File: rtl/srec_stream_decoder.sv
// srec_stream_decoder: top of the S-record decoder. It accepts one ASCII
// character per handshake and turns the records into memory writes,
// checksum and format verdicts, and an address range.
// Assumes: the downstream memory takes a write every cycle. The decoder
// applies no backpressure after reset.
module srec_stream_decoder #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              cksum_err,
    output logic              fmt_err,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic              addr_seen
);

    logic       acc;
    logic       is_hex;
    logic [3:0] nib;
    logic       in_hex_field;
    logic       byte_done;
    logic [7:0] byte_val;

    // Raise ready one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // A character is consumed when it is offered and ready is high.
    always_comb acc = in_valid && in_ready;

    srec_hex_nibble u_hex (
        .ch     (in_char),
        .is_hex (is_hex),
        .nib    (nib)
    );

    srec_byte_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!in_hex_field),
        .take      (acc && is_hex && in_hex_field),
        .nib       (nib),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    srec_record_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc          (acc),
        .ch           (in_char),
        .is_hex       (is_hex),
        .byte_done    (byte_done),
        .byte_val     (byte_val),
        .in_hex_field (in_hex_field),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .done         (done),
        .cksum_err    (cksum_err),
        .fmt_err      (fmt_err)
    );

    srec_range_track #(.ADDR_W(ADDR_W)) u_range (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi),
        .addr_seen (addr_seen)
    );

endmodule

// File: rtl/srec_decoder_chk.sv
// srec_decoder_chk: temporal checks on the ports of srec_stream_decoder,
// attached to it with the bind statement at the end of this file.
// Assumes: synchronous active-low reset. past_ok masks the first cycle
// after reset, so no check looks back past the reset.
module srec_decoder_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done,
    input logic              cksum_err,
    input logic              fmt_err,
    input logic [ADDR_W-1:0] addr_lo,
    input logic [ADDR_W-1:0] addr_hi,
    input logic              addr_seen
);

    logic past_ok;

    // Mark the cycles for which $past refers to a post-reset sample.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_ready_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> in_ready);

    p_write_follows_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_en) |-> $past(in_valid && in_ready));

    p_write_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_no_event_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(in_valid && in_ready)) |-> !(wr_en || done || cksum_err || fmt_err));

    p_verdict_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, cksum_err, fmt_err}));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cksum_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cksum_err |=> !cksum_err);

    p_range_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_seen |-> (addr_lo <= addr_hi));

    p_range_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (addr_seen && addr_lo <= $past(wr_addr) && addr_hi >= $past(wr_addr)));

    p_range_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !wr_en) |=> ($stable(addr_lo) && $stable(addr_hi)));

endmodule

bind srec_stream_decoder srec_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .done      (done),
    .cksum_err (cksum_err),
    .fmt_err   (fmt_err),
    .addr_lo   (addr_lo),
    .addr_hi   (addr_hi),
    .addr_seen (addr_seen)
);

// File: tb/sim_srec_stream_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected writes and verdicts into
// queues, and a monitor pops and compares them as the decoder produces them.
module sim_srec_stream_decoder;

    localparam int ADDR_W = 32;
    localparam int EV_DONE = 1;
    localparam int EV_CSUM = 2;
    localparam int EV_FMT  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_char = 8'h00;
    logic              in_ready;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              done;
    logic              cksum_err;
    logic              fmt_err;
    logic [ADDR_W-1:0] addr_lo;
    logic [ADDR_W-1:0] addr_hi;
    logic              addr_seen;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [39:0] wq[$];   // {addr, data}
    int          evq[$];
    string       evtag[$];
    logic [31:0] exp_lo = 32'hFFFF_FFFF;
    logic [31:0] exp_hi = 32'h0;

    always #4 clk = ~clk;   // 125 MHz

    srec_stream_decoder #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .cksum_err(cksum_err), .fmt_err(fmt_err),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .addr_seen(addr_seen)
    );

    task automatic check_eq(input string tag, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

    task automatic push_wr(input logic [31:0] a, input logic [7:0] d);
        wq.push_back({a, d});
        if (a < exp_lo) exp_lo = a;
        if (a > exp_hi) exp_hi = a;
    endtask

    task automatic push_ev(input int code, input string tag);
        evq.push_back(code);
        evtag.push_back(tag);
    endtask

    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = c;
        @(posedge clk);
        while (!in_ready) @(posedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_char(hexc(b[7:4]));
        send_char(hexc(b[3:0]));
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Build one record with its checksum and queue what it should produce.
    // Byte i of the payload is dat[63-8*i -: 8].
    task automatic send_rec(input int typ, input logic [31:0] addr,
                            input logic [63:0] dat, input int n, input bit bad);
        int         alen;
        logic [7:0] cnt;
        logic [7:0] sum;
        logic [7:0] cs;
        alen = (typ == 2 || typ == 8) ? 3 : ((typ == 3 || typ == 7) ? 4 : 2);
        cnt  = 8'(alen + n + 1);
        sum  = cnt;
        for (int i = 0; i < alen; i++) sum = sum + addr[8*i +: 8];
        for (int i = 0; i < n; i++) sum = sum + dat[63-8*i -: 8];
        cs = 8'hFF - sum;
        if (bad) cs = cs + 8'd1;
        if (typ >= 1 && typ <= 3)
            for (int i = 0; i < n; i++) push_wr(addr + 32'(i), dat[63-8*i -: 8]);
        if (bad)           push_ev(EV_CSUM, (typ >= 7) ? "R10" : "R9");
        else if (typ >= 7) push_ev(EV_DONE, "R10");
        send_char(8'h53);
        send_char(hexc(4'(typ)));
        send_byte(cnt);
        for (int i = alen - 1; i >= 0; i--) send_byte(addr[8*i +: 8]);
        for (int i = 0; i < n; i++) send_byte(dat[63-8*i -: 8]);
        send_byte(cs);
        send_char(8'h0D);
        send_char(8'h0A);
    endtask

    // Monitor: compare writes and verdict pulses against the queues.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (wr_en) begin
                if (wq.size() == 0) begin
                    check_eq("R8", "write with none expected", {32'h0, wr_addr}, 64'hFFFF_FFFF_FFFF_FFFF);
                end else begin
                    logic [39:0] e;
                    e = wq.pop_front();
                    check_eq("R7", "write address", {32'h0, wr_addr}, {32'h0, e[39:8]});
                    check_eq("R7", "write data", {56'h0, wr_data}, {56'h0, e[7:0]});
                end
            end
            if (done || cksum_err || fmt_err) begin
                int ev;
                ev = ({done, cksum_err, fmt_err} == 3'b100) ? EV_DONE :
                     ({done, cksum_err, fmt_err} == 3'b010) ? EV_CSUM :
                     ({done, cksum_err, fmt_err} == 3'b001) ? EV_FMT : 7;
                if (evq.size() == 0) begin
                    check_eq("R12", "verdict with none expected", 64'(ev), 64'd0);
                end else begin
                    string t;
                    int    x;
                    x = evq.pop_front();
                    t = evtag.pop_front();
                    check_eq(t, "verdict pulse code", 64'(ev), 64'(x));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "outputs in reset", {60'h0, wr_en, done, cksum_err, fmt_err}, 64'h0);
        check_eq("R1", "addr_lo in reset", {32'h0, addr_lo}, 64'hFFFF_FFFF);
        check_eq("R1", "addr_hi/seen in reset", {31'h0, addr_hi, addr_seen}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "outputs after reset", {60'h0, wr_en, done, cksum_err, fmt_err}, 64'h0);
        @(negedge clk);
        check_eq("R1", "in_ready after reset", {63'h0, in_ready}, 64'h1);

        // R2: line ends are ignored, stray character flagged
        send_char(8'h0D); send_char(8'h0A);
        push_ev(EV_FMT, "R2");
        send_char(8'h58);
        // Literal 16-bit record: writes 01..04 at 0100..0103, passes checksum
        push_wr(32'h0100, 8'h01); push_wr(32'h0101, 8'h02);
        push_wr(32'h0102, 8'h03); push_wr(32'h0103, 8'h04);
        send_str("S107010001020304ED");
        send_char(8'h0A);
        // R5: 24-bit and 32-bit addresses, carry across bit 16
        send_rec(2, 32'h0012_3456, 64'hA1B2C300_00000000, 3, 1'b0);
        send_rec(3, 32'h8000_FFFE, 64'h11223344_00000000, 4, 1'b0);
        // R8: header payload is not written
        send_rec(0, 32'h0, 64'h48445200_00000000, 3, 1'b0);
        // R9: bad checksum, writes stay and feed the range
        send_rec(1, 32'h0040, 64'h5A5B0000_00000000, 2, 1'b1);
        // R4: lower-case hex digits
        push_wr(32'h0200, 8'hAA); push_wr(32'h0201, 8'hBB);
        send_str("S1050200aabb93");
        // R3: unsupported type digit
        push_ev(EV_FMT, "R3");
        send_str("S4");
        // R6: count smaller than address plus checksum
        push_ev(EV_FMT, "R6");
        send_str("S102");
        send_char(8'h0A);
        // R4: non-hex character inside a record aborts it
        push_ev(EV_FMT, "R4");
        send_str("S10701G");
        send_char(8'h0A);
        // R6: record with no data bytes is valid and writes nothing
        send_rec(1, 32'h0300, 64'h0, 0, 1'b0);
        // R10: end records of each width, one failing
        send_rec(9, 32'h0100, 64'h0, 0, 1'b1);
        send_rec(9, 32'h0100, 64'h0, 0, 1'b0);
        send_rec(8, 32'h0012_3456, 64'hEE000000_00000000, 1, 1'b0);
        send_rec(7, 32'h8000_0000, 64'h0, 0, 1'b0);
        go_idle();
        repeat (6) @(negedge clk);

        check_eq("R7", "writes left unseen", 64'(wq.size()), 64'd0);
        check_eq("R9", "verdicts left unseen", 64'(evq.size()), 64'd0);
        check_eq("R11", "lowest address", {32'h0, addr_lo}, {32'h0, exp_lo});
        check_eq("R11", "highest address", {32'h0, addr_hi}, {32'h0, exp_hi});
        check_eq("R11", "address seen", {63'h0, addr_seen}, 64'h1);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule